// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell Array

This block models a small field-configurable logic array. Twelve dedicated inputs and ten macrocell feedback lines reach an AND plane in both true and inverted form. Each product term picks any set of those literals through a configuration vector that is held steady while the array runs. Each macrocell ORs its own group of product terms. The groups differ in size. The macrocell then applies a programmable polarity and either drives the result straight out or stores it in a D flip-flop on the shared clock.

Four more kinds of product term have special jobs. One term per macrocell drives that macrocell's output enable. A single term clears every register at once, without waiting for a clock. A single term sets every register at the next clock edge. A test preload path can also force the whole register bank to any pattern on a clock edge. The pins are modelled as a value and enable pair for each macrocell, plus a separate pin-input vector that the surrounding logic supplies.

A system that also wants the clock pin's level in the logic ties that level to `ded_in[0]`.

Top module: `sop_macro_array`

## Requirements
- R1: When `rst` is high at a rising `clk` edge, every register becomes 0. A registered macrocell then shows 0 on `io_out` if it is active-high and 1 if it is active-low. `rst` outranks preload and the set term.
- R2: Product term t owns `cfg_fuses[t*44 +: 44]`. Within it, bit 2s selects signal s true and bit 2s+1 selects signal s inverted. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are the feedback of macrocells 0..9. A term is the AND of its selected literals. A term with no bit selected is 0.
- R3: Macrocell m owns a contiguous run of terms. The run sizes for m = 0..9 are 8,10,12,14,16,16,14,12,10,8, giving 120 terms in total, and each run starts where the previous one ends, beginning at term 0.
- R4: Mode bits lie at `cfg_fuses[5808+2m]` (active-low) and `cfg_fuses[5809+2m]` (registered). In combinatorial mode, `io_out[m]` is the OR of the macrocell's terms, inverted when the active-low bit is 1.
- R5: In registered mode, the register loads the OR of the macrocell's terms at each clock edge, and `io_out[m]` shows the register, inverted when the active-low bit is 1.
- R6: A registered macrocell feeds its register value back to the array. A combinatorial macrocell feeds back `io_in[m]`.
- R7: Term 120+m drives `io_oe[m]`. `io_out[m]` keeps its value whatever the enable.
- R8: While term 130 is true, every register is 0 at once, with no clock edge needed. This clear outranks `rst`, preload and the set term.
- R9: When term 131 is true at a clock edge, every register becomes 1, unless a clear, `rst` or preload applies.
- R10: When `preload_en` is high at a clock edge, each register m loads `preload_val[m]`. Preload outranks the set term and the OR input, and is outranked by the clear term and `rst`.
- R11: When terms 130 and 131 are both true at a clock edge, the registers end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| cfg_fuses | input | 5828 | Configuration vector: AND-plane selections, then mode bits |
| ded_in | input | 12 | Dedicated array inputs |
| io_in | input | 10 | Level seen at each macrocell pin |
| preload_en | input | 1 | Load `preload_val` into the registers at the clock edge |
| preload_val | input | 10 | Preload pattern, one bit per macrocell |
| io_out | output | 10 | Value each macrocell drives |
| io_oe | output | 10 | Output enable of each macrocell |

## Verification
The bench uses one-hot and one-cold patterns on the dedicated inputs against single terms placed at the first and last slot of each run. An off-by-one in the term allocation then lights the wrong output. Chosen feedback chains drive a pin input that differs from the register value, so the two feedback sources give different outputs. Stacked control patterns fire clear, set, preload and reset together in pairs, which shows their order of priority. Random configurations with random inputs exercise all four modes, OR sums of different widths and enable terms against a cycle model in the bench.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef struct packed {
    logic registered;
    logic active_low;
  } mc_mode_t;

  // Terms allotted to macrocell m: grows toward the middle, mirrored.
  function automatic int pt_alloc(int m, int n_mc, int pt_min, int pt_step);
    int rank;
    rank = (m < n_mc / 2) ? m : (n_mc - 1 - m);
    return pt_min + pt_step * rank;
  endfunction

  // First term index of macrocell m (sum of all earlier allocations).
  function automatic int pt_base(int m, int n_mc, int pt_min, int pt_step);
    int acc;
    acc = 0;
    for (int k = 0; k < m; k++) acc += pt_alloc(k, n_mc, pt_min, pt_step);
    return acc;
  endfunction

endpackage

// File: rtl/sop_literal_bus.sv
module sop_literal_bus #(
  parameter int NUM_DED = 12,
  parameter int NUM_MC  = 10,
  localparam int NUM_SIG = NUM_DED + NUM_MC,
  localparam int NUM_COL = 2 * NUM_SIG
) (
  input  logic [NUM_DED-1:0] ded_in,
  input  logic [NUM_MC-1:0]  pin_in,
  input  logic [NUM_MC-1:0]  reg_q,
  input  logic [NUM_MC-1:0]  reg_mode,
  output logic [NUM_COL-1:0] lits
);

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    logic sig;
    if (s < NUM_DED) begin : g_ded
      assign sig = ded_in[s];
    end else begin : g_fb
      localparam int K = s - NUM_DED;
      // registered cells feed back the flop, others the pin level
      assign sig = reg_mode[K] ? reg_q[K] : pin_in[K];
    end
    assign lits[2*s]   = sig;
    assign lits[2*s+1] = ~sig;
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int NUM_COL = 44,
  parameter int NUM_PT  = 132,
  localparam int FUSE_W = NUM_PT * NUM_COL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FUSE_W-1:0]  fuses,
  input  logic [NUM_COL-1:0] lits,
  output logic [NUM_PT-1:0]  terms
);

  for (genvar t = 0; t < NUM_PT; t++) begin : g_pt
    logic [NUM_COL-1:0] sel;
    logic any_sel;
    logic all_met;
    assign sel     = fuses[t*NUM_COL +: NUM_COL];
    assign any_sel = |sel;
    assign all_met = &(lits | ~sel);
    assign terms[t] = any_sel & all_met;

    AST_EMPTY_TERM_OFF: assert property (@(posedge clk) disable iff (rst)
      (fuses[t*NUM_COL +: NUM_COL] == '0) |-> !terms[t]); // R2
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int PT_N = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PT_N-1:0] sum_terms,
  input  logic            oe_term,
  input  logic            async_clr,
  input  logic            sync_set,
  input  logic            preload_en,
  input  logic            preload_bit,
  input  mc_mode_t        mode,
  output logic            pin_val,
  output logic            pin_oe,
  output logic            q_out
);

  logic sum_or;
  logic q_r;

  assign sum_or = |sum_terms;

  always_ff @(posedge clk or posedge async_clr) begin
    if (async_clr)       q_r <= 1'b0;
    else if (rst)        q_r <= 1'b0;
    else if (preload_en) q_r <= preload_bit;
    else if (sync_set)   q_r <= 1'b1;
    else                 q_r <= sum_or;
  end

  assign q_out   = q_r;
  assign pin_val = (mode.registered ? q_r : sum_or) ^ mode.active_low;
  assign pin_oe  = oe_term;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (async_clr)
    rst |=> !q_out); // R1
  AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    async_clr |-> !q_out); // R8
  AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (rst)
    (async_clr && sync_set) |=> !q_out); // R11
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst || async_clr)
    (sync_set && !preload_en) |=> q_out); // R9
  AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (rst || async_clr)
    preload_en |=> (q_out == $past(preload_bit))); // R10
  AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (rst || async_clr)
    (!preload_en && !sync_set) |=> (q_out == $past(|sum_terms))); // R5

endmodule

// File: rtl/sop_macro_array.sv
module sop_macro_array
  import sop_pkg::*;
#(
  parameter int NUM_DED = 12,
  parameter int NUM_MC  = 10,
  parameter int PT_MIN  = 8,
  parameter int PT_STEP = 2,
  localparam int NUM_SIG   = NUM_DED + NUM_MC,
  localparam int NUM_COL   = 2 * NUM_SIG,
  localparam int SUM_PT    = pt_base(NUM_MC, NUM_MC, PT_MIN, PT_STEP),
  localparam int OE_BASE   = SUM_PT,
  localparam int CLR_IDX   = SUM_PT + NUM_MC,
  localparam int SET_IDX   = CLR_IDX + 1,
  localparam int NUM_PT    = SET_IDX + 1,
  localparam int MODE_BASE = NUM_PT * NUM_COL,
  localparam int CFG_W     = MODE_BASE + 2 * NUM_MC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   cfg_fuses,
  input  logic [NUM_DED-1:0] ded_in,
  input  logic [NUM_MC-1:0]  io_in,
  input  logic               preload_en,
  input  logic [NUM_MC-1:0]  preload_val,
  output logic [NUM_MC-1:0]  io_out,
  output logic [NUM_MC-1:0]  io_oe
);

  logic [NUM_COL-1:0] lits;
  logic [NUM_PT-1:0]  terms;
  logic [NUM_MC-1:0]  reg_q;
  logic [NUM_MC-1:0]  reg_mode;

  sop_literal_bus #(
    .NUM_DED (NUM_DED),
    .NUM_MC  (NUM_MC)
  ) i_lits (
    .ded_in   (ded_in),
    .pin_in   (io_in),
    .reg_q    (reg_q),
    .reg_mode (reg_mode),
    .lits     (lits)
  );

  sop_and_plane #(
    .NUM_COL (NUM_COL),
    .NUM_PT  (NUM_PT)
  ) i_plane (
    .clk   (clk),
    .rst   (rst),
    .fuses (cfg_fuses[MODE_BASE-1:0]),
    .lits  (lits),
    .terms (terms)
  );

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    localparam int BASE = pt_base(m, NUM_MC, PT_MIN, PT_STEP);
    localparam int CNT  = pt_alloc(m, NUM_MC, PT_MIN, PT_STEP);
    mc_mode_t mode_m;
    assign mode_m      = cfg_fuses[MODE_BASE + 2*m +: 2];
    assign reg_mode[m] = mode_m.registered;

    sop_macrocell #(
      .PT_N (CNT)
    ) i_mc (
      .clk         (clk),
      .rst         (rst),
      .sum_terms   (terms[BASE +: CNT]),
      .oe_term     (terms[OE_BASE + m]),
      .async_clr   (terms[CLR_IDX]),
      .sync_set    (terms[SET_IDX]),
      .preload_en  (preload_en),
      .preload_bit (preload_val[m]),
      .mode        (mode_m),
      .pin_val     (io_out[m]),
      .pin_oe      (io_oe[m]),
      .q_out       (reg_q[m])
    );
  end

endmodule

// File: tb/test_sop_macro_array.sv
module test_sop_macro_array;

  localparam int NCOL  = 44;
  localparam int NPT   = 132;
  localparam int OE_B  = 120;
  localparam int CLR_I = 130;
  localparam int SET_I = 131;
  localparam int MB    = NPT * NCOL;
  localparam int CFGW  = MB + 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CFGW-1:0] cfg = '0;
  logic [11:0]     ded_in = 12'h800;
  logic [9:0]      io_in = '0;
  logic            preload_en = 1'b0;
  logic [9:0]      preload_val = '0;
  logic [9:0]      io_out, io_oe;

  logic [9:0] qm = '0;
  logic [9:0] got_out, got_oe;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_macro_array i_sop_macro_array (
    .clk(clk), .rst(rst), .cfg_fuses(cfg), .ded_in(ded_in), .io_in(io_in),
    .preload_en(preload_en), .preload_val(preload_val),
    .io_out(io_out), .io_oe(io_oe)
  );

  function automatic int alloc_of(int m);
    case (m)
      0, 9: return 8;
      1, 8: return 10;
      2, 7: return 12;
      3, 6: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic int base_of(int m);
    int b;
    b = 0;
    for (int k = 0; k < m; k++) b += alloc_of(k);
    return b;
  endfunction

  function automatic logic [NCOL-1:0] lits_of(logic [11:0] d, logic [9:0] io, logic [9:0] q);
    logic [NCOL-1:0] l;
    for (int s = 0; s < 22; s++) begin
      logic v;
      if (s < 12) v = d[s];
      else v = cfg[MB + 2*(s-12) + 1] ? q[s-12] : io[s-12];
      l[2*s] = v;
      l[2*s+1] = ~v;
    end
    return l;
  endfunction

  function automatic logic term_of(int t, logic [NCOL-1:0] l);
    logic any, ok;
    any = 1'b0; ok = 1'b1;
    for (int c = 0; c < NCOL; c++)
      if (cfg[t*NCOL + c]) begin
        any = 1'b1;
        if (!l[c]) ok = 1'b0;
      end
    return any & ok;
  endfunction

  function automatic logic sum_of(int m, logic [NCOL-1:0] l);
    logic r;
    r = 1'b0;
    for (int k = 0; k < alloc_of(m); k++) r |= term_of(base_of(m) + k, l);
    return r;
  endfunction

  task automatic set_lit(int t, int c);
    cfg[t*NCOL + c] = 1'b1;
  endtask

  task automatic set_mode(int m, logic low, logic regd);
    cfg[MB + 2*m] = low;
    cfg[MB + 2*m + 1] = regd;
  endtask

  task automatic chk10(logic [9:0] act, logic [9:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [11:0] d, input logic [9:0] io, input logic pe,
                           input logic [9:0] pv, input logic r, input bit chk, input string tag);
    logic [NCOL-1:0] l;
    logic [9:0] eo, eoe, nq;
    logic clr, st;
    @(negedge clk);
    ded_in = d; io_in = io; preload_en = pe; preload_val = pv; rst = r;
    #1;
    l = lits_of(d, io, qm);
    clr = term_of(CLR_I, l);
    if (clr) begin
      qm = '0;
      l = lits_of(d, io, qm);
    end
    for (int m = 0; m < 10; m++) begin
      logic s;
      s = sum_of(m, l);
      eo[m] = (cfg[MB + 2*m + 1] ? qm[m] : s) ^ cfg[MB + 2*m];
      eoe[m] = term_of(OE_B + m, l);
      nq[m] = s;
    end
    st = term_of(SET_I, l);
    got_out = io_out;
    got_oe = io_oe;
    if (chk) begin
      n_chk++;
      if (got_out !== eo || got_oe !== eoe) begin
        n_fail++;
        $display("FAIL %s: actual out=%h oe=%h expected out=%h oe=%h", tag, got_out, got_oe, eo, eoe);
      end
    end
    @(posedge clk);
    if (clr || r) qm = '0;
    else if (pe) qm = pv;
    else if (st) qm = '1;
    else qm = nq;
  endtask

  task automatic do_reset();
    run_cycle(12'h800, '0, 1'b0, '0, 1'b1, 0, "reset");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b1, 0, "reset");
  endtask

  task automatic oe_on_all();
    for (int m = 0; m < 10; m++) set_lit(OE_B + m, 22);
  endtask

  task automatic rand_cfg();
    cfg = '0;
    for (int t = 0; t < NPT; t++) begin
      if (t == CLR_I) begin
        if ($urandom % 3 == 0)
          for (int c = 0; c < 24; c++) if ($urandom % 4 == 0) set_lit(t, c);
      end else begin
        for (int c = 0; c < NCOL; c++) if ($urandom % 14 == 0) set_lit(t, c);
      end
    end
    for (int b = 0; b < 20; b++) cfg[MB + b] = 1'($urandom % 2);
  endtask

  initial begin
    void'($urandom(32'd5117));

    // R1: reset state, active-low cells read high
    cfg = '0;
    oe_on_all();
    for (int m = 0; m < 10; m++) set_mode(m, m >= 5, 1'b1);
    do_reset();
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R1");
    chk10(got_out, 10'h3E0, "R1 reset out");
    chk10(got_oe, 10'h3FF, "R7 oe on");

    // R2 R4: empty terms and self-contradicting term read 0
    cfg = '0;
    oe_on_all();
    for (int m = 0; m < 10; m++) set_mode(m, (m % 2) == 0, 1'b0);
    set_lit(base_of(0), 0);
    set_lit(base_of(0), 1);
    do_reset();
    run_cycle(12'hABC, '0, 1'b0, '0, 1'b0, 1, "R2");
    chk10(got_out, 10'h155, "R2 R4 empty term");

    // R3: last and first slot of each run
    cfg = '0;
    oe_on_all();
    for (int m = 0; m < 10; m++) set_lit(base_of(m) + alloc_of(m) - 1, 2*m);
    do_reset();
    for (int k = 0; k < 10; k++) begin
      run_cycle(12'h800 | (12'd1 << k), '0, 1'b0, '0, 1'b0, 0, "R3");
      chk10(got_out, 10'd1 << k, "R3 last slot");
    end
    cfg = '0;
    oe_on_all();
    for (int m = 0; m < 10; m++) set_lit(base_of(m), 2*m + 1);
    do_reset();
    for (int k = 0; k < 10; k++) begin
      run_cycle(12'h800 | (12'h3FF & ~(12'd1 << k)), '0, 1'b0, '0, 1'b0, 0, "R3");
      chk10(got_out, 10'd1 << k, "R3 first slot");
    end

    // R5 R6: feedback sources
    cfg = '0;
    oe_on_all();
    set_mode(0, 1'b0, 1'b1);
    set_lit(base_of(0), 0);
    set_lit(base_of(1), 24);
    set_lit(base_of(2), 30);
    do_reset();
    run_cycle(12'h801, '0, 1'b0, '0, 1'b0, 1, "R5");
    chk10(got_out, 10'h000, "R5 before capture");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R6");
    chk10(got_out, 10'h003, "R5 R6 register feedback");
    run_cycle(12'h800, 10'h008, 1'b0, '0, 1'b0, 1, "R6");
    chk10(got_out, 10'h004, "R6 pin feedback");

    // R7: enable term off, value unaffected
    cfg = '0;
    for (int m = 0; m < 10; m++) begin
      set_lit(OE_B + m, 21);
      set_mode(m, 1'b1, 1'b0);
    end
    do_reset();
    run_cycle(12'hC00, '0, 1'b0, '0, 1'b0, 1, "R7");
    chk10(got_oe, 10'h000, "R7 disabled");
    chk10(got_out, 10'h3FF, "R7 value kept");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R7");
    chk10(got_oe, 10'h3FF, "R7 enabled");

    // R8 R9 R10 R11: clear, set, preload, priorities
    cfg = '0;
    oe_on_all();
    for (int m = 0; m < 10; m++) set_mode(m, 1'b0, 1'b1);
    set_lit(SET_I, 2);
    set_lit(CLR_I, 4);
    do_reset();
    run_cycle(12'h806, '0, 1'b0, '0, 1'b0, 1, "R11");
    run_cycle(12'h802, '0, 1'b0, '0, 1'b0, 1, "R11");
    chk10(got_out, 10'h000, "R11 clear beats set");
    run_cycle(12'h802, '0, 1'b0, '0, 1'b0, 1, "R9");
    chk10(got_out, 10'h3FF, "R9 set");
    run_cycle(12'h806, '0, 1'b0, '0, 1'b0, 1, "R8");
    chk10(got_out, 10'h000, "R8 clear without edge");
    run_cycle(12'h802, '0, 1'b1, 10'h2A5, 1'b0, 1, "R10");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R10");
    chk10(got_out, 10'h2A5, "R10 preload beats set");
    run_cycle(12'h804, '0, 1'b1, 10'h3FF, 1'b0, 1, "R8");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R8");
    chk10(got_out, 10'h000, "R8 clear beats preload");
    run_cycle(12'h802, '0, 1'b1, 10'h3FF, 1'b1, 1, "R1");
    run_cycle(12'h800, '0, 1'b0, '0, 1'b0, 1, "R1");
    chk10(got_out, 10'h000, "R1 reset beats preload and set");

    // Random configurations: R2 R4 R5 R6 R7 R9 R10
    for (int n = 0; n < 6; n++) begin
      rand_cfg();
      do_reset();
      for (int c = 0; c < 300; c++)
        run_cycle(12'($urandom), 10'($urandom), ($urandom % 16) == 0, 10'($urandom),
                  ($urandom % 64) == 0, 1, "random R4 R5 R6 R7");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule